// File: doc/BRIEF.md
# Shared Full-Flag Bus Ownership Controller

This block sits at the write side of a multi-queue storage device that can be chained with up to seven others. All chained devices drive one common full-flag line, so at any moment exactly one of them has to drive it while the rest stay off the line. The block holds a small device number and a leader/follower role. It checks each write-queue selection against that number, and from that decides whether this device drives the shared flag.

The device number and the role are sampled from configuration pins while the active-low reset is held, on each write-clock edge. Once reset is released they are frozen. The top bits of each selected write address name a device. When they equal the stored number, this device takes the flag line on the cycle after the selection edge, and the low address bits are kept as the local queue index. When they differ, the device lets go of the line on the next cycle. A leader owns the line from reset until the first selection, and a follower starts off the line. The full status itself comes from the queue logic outside this block. It is registered on the write clock and presented as a value output, with a separate output-enable that stands for the high-impedance control.

Top module: `fbus_share_ctrl`

## Requirements
- R1: The device number (`dev_id_i`, 3 bits) and role (`leader_i`, 1 = leader) are captured on every write-clock edge while `rst_ni` is low. Changes on those pins after reset release have no effect on address matching or on ownership.
- R2: After reset release and before any selection, `flag_oe_o` equals the captured role: 1 for a leader, 0 for a follower. This holds for any device number, including nonzero numbers on a leader.
- R3: A selection (`wr_sel_i` high at a clock edge) whose address bit 7 equals device-number bit 2 and whose address bits 6:5 equal device-number bits 1:0 drives `flag_oe_o` to 1 from that edge onward.
- R4: A selection whose address top three bits differ from the device number drives `flag_oe_o` to 0 from that edge onward.
- R5: While `wr_sel_i` is low, `flag_oe_o` holds its value whatever `wr_addr_i` carries.
- R6: `full_o` equals `full_int_i` as sampled at the previous write-clock edge, and it is 0 after reset.
- R7: On a matching selection, `local_q_o` takes address bits 4:0 from that edge. Non-matching selections and idle cycles leave it unchanged. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Active-low asynchronous master reset; configuration is sampled while low |
| dev_id_i | input | 3 | Device number pins |
| leader_i | input | 1 | Role pin, 1 = leader |
| wr_sel_i | input | 1 | Write-queue selection strobe |
| wr_addr_i | input | 8 | Write queue address |
| full_int_i | input | 1 | Internal full status of the selected queue |
| full_o | output | 1 | Registered full-flag value |
| flag_oe_o | output | 1 | Drive enable for the shared flag line (0 = high impedance) |
| local_q_o | output | 5 | Local queue index of the last matching selection |

## Verification
The bench builds the block with its default widths: a 3-bit device number and an 8-bit address. With those widths every one of the eight device numbers and all 256 addresses are reachable, so a full address sweep under several device numbers and both roles covers every match and mismatch. A behavioural reference model, compared every cycle, tracks ownership handover, queue-index capture and the one-cycle flag delay. Directed steps cover configuration pins changing after reset, address changes while the strobe is low, and a leader whose number is not zero.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  parameter int unsigned DEF_ID_W   = 3;
  parameter int unsigned DEF_ADDR_W = 8;

  typedef enum logic {
    ROLE_FOLLOWER = 1'b0,
    ROLE_LEADER   = 1'b1
  } role_e;
endpackage

// File: rtl/fbus_cfg_capture.sv
module fbus_cfg_capture #(
  parameter int unsigned ID_W = fbus_pkg::DEF_ID_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] dev_id_i,
  input  logic            leader_i,
  output logic [ID_W-1:0] id_o,
  output fbus_pkg::role_e role_o
);
  import fbus_pkg::*;

  logic [ID_W-1:0] id_q;
  role_e           role_q;

  // configuration loads only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      id_q   <= dev_id_i;
      role_q <= leader_i ? ROLE_LEADER : ROLE_FOLLOWER;
    end
  end

  assign id_o   = id_q;
  assign role_o = role_q;

  // R1
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($stable(id_q) && $stable(role_q)));
endmodule

// File: rtl/fbus_addr_decode.sv
module fbus_addr_decode #(
  parameter int unsigned ADDR_W = fbus_pkg::DEF_ADDR_W,
  parameter int unsigned ID_W   = fbus_pkg::DEF_ID_W,
  localparam int unsigned LQ_W  = ADDR_W - ID_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              hit_o,
  output logic [LQ_W-1:0]   lq_o
);
  logic [ID_W-1:0] bit_eq;

  // top address bits line up with device-number bits, MSB to MSB
  for (genvar g = 0; g < ID_W; g++) begin : g_cmp
    assign bit_eq[g] = ~(addr_i[LQ_W+g] ^ id_i[g]);
  end

  assign hit_o = &bit_eq;
  assign lq_o  = addr_i[LQ_W-1:0];
endmodule

// File: rtl/fbus_owner_ctrl.sv
module fbus_owner_ctrl (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            hit_i,
  input  fbus_pkg::role_e role_i,
  output logic            oe_o
);
  import fbus_pkg::*;

  logic boot_q;  // no selection seen since reset
  logic own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      own_q  <= 1'b0;
    end else if (sel_i) begin
      boot_q <= 1'b0;
      own_q  <= hit_i;
    end
  end

  assign oe_o = boot_q ? (role_i == ROLE_LEADER) : own_q;

  // R3
  take_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && hit_i) |=> oe_o);
  // R4
  release_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !hit_i) |=> !oe_o);
  // R5
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(oe_o));
  // R2
  boot_role_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_q |-> (oe_o == (role_i == ROLE_LEADER)));
endmodule

// File: rtl/fbus_share_ctrl.sv
module fbus_share_ctrl #(
  parameter int unsigned ID_W   = fbus_pkg::DEF_ID_W,
  parameter int unsigned ADDR_W = fbus_pkg::DEF_ADDR_W,
  localparam int unsigned LQ_W  = ADDR_W - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              leader_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              full_int_i,
  output logic              full_o,
  output logic              flag_oe_o,
  output logic [LQ_W-1:0]   local_q_o
);
  import fbus_pkg::*;

  logic [ID_W-1:0] id;
  role_e           role;
  logic            hit;
  logic [LQ_W-1:0] lq;
  logic            full_q;
  logic [LQ_W-1:0] lq_q;

  fbus_cfg_capture #(.ID_W(ID_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dev_id_i (dev_id_i),
    .leader_i (leader_i),
    .id_o     (id),
    .role_o   (role)
  );

  fbus_addr_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dec (
    .addr_i (wr_addr_i),
    .id_i   (id),
    .hit_o  (hit),
    .lq_o   (lq)
  );

  fbus_owner_ctrl u_own (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (wr_sel_i),
    .hit_i  (hit),
    .role_i (role),
    .oe_o   (flag_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      lq_q   <= '0;
    end else begin
      full_q <= full_int_i;
      if (wr_sel_i && hit) lq_q <= lq;
    end
  end

  assign full_o    = full_q;
  assign local_q_o = lq_q;

  // R6
  full_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (full_o == $past(full_int_i)));
  // R7
  lq_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i && hit) |=> (local_q_o == $past(wr_addr_i[LQ_W-1:0])));
  // R7
  lq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_sel_i && hit) |=> $stable(local_q_o));
endmodule

// File: tb/fbus_share_ctrl_test.sv
`timescale 1ns/1ps
module fbus_share_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] dev_id_i = '0;
  logic       leader_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic       full_int_i = 1'b0;
  logic       full_o, flag_oe_o;
  logic [4:0] local_q_o;

  always #5 clk_i = ~clk_i;

  fbus_share_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dev_id_i(dev_id_i), .leader_i(leader_i),
    .wr_sel_i(wr_sel_i), .wr_addr_i(wr_addr_i), .full_int_i(full_int_i),
    .full_o(full_o), .flag_oe_o(flag_oe_o), .local_q_o(local_q_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "reset";

  // behavioural reference
  int   m_id = 0;
  bit   m_leader = 0;
  bit   m_cfg_ok = 0;
  bit   m_boot = 1;
  bit   m_own = 0;
  int   m_lq = 0;
  bit   m_full = 0;

  always @(negedge rst_ni) begin
    m_boot = 1; m_own = 0; m_lq = 0; m_full = 0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_id = int'(dev_id_i); m_leader = leader_i; m_cfg_ok = 1;
    end else begin
      if (wr_sel_i) begin
        m_boot = 0;
        if (int'(wr_addr_i) / 32 == m_id) begin
          m_own = 1; m_lq = int'(wr_addr_i) % 32;
        end else m_own = 0;
      end
      m_full = full_int_i;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_oe;
    if (!m_cfg_ok) return;
    exp_oe = m_boot ? int'(m_leader) : int'(m_own);
    chk(int'(flag_oe_o) == exp_oe, "flag_oe", int'(flag_oe_o), exp_oe);
    if (rst_ni) begin
      chk(int'(full_o) == int'(m_full), "R6 full", int'(full_o), int'(m_full));
      chk(int'(local_q_o) == m_lq, "R7 local_q", int'(local_q_o), m_lq);
    end
  endtask

  task automatic step(input bit sel, input int addr, input bit full);
    @(negedge clk_i);
    compare();
    wr_sel_i = sel; wr_addr_i = addr[7:0]; full_int_i = full;
  endtask

  task automatic do_reset(input int id, input bit lead);
    @(negedge clk_i);
    rst_ni = 1'b0; dev_id_i = id[2:0]; leader_i = lead; wr_sel_i = 1'b0;
    repeat (3) step(0, 0, 0);
    // reset state
    chk(full_o == 1'b0, "R6 reset full", int'(full_o), 0);
    chk(local_q_o == 5'd0, "R7 reset local_q", int'(local_q_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired in %s", phase);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // leader with nonzero number
    phase = "R2 leader id5";
    do_reset(5, 1);
    for (int i = 0; i < 4; i++) step(0, $urandom_range(0, 255), 1'($urandom));
    step(0, 0, 0);
    chk(flag_oe_o == 1'b1, "R2 leader owns", int'(flag_oe_o), 1);

    // pins change after reset
    phase = "R1 pins frozen";
    dev_id_i = 3'd2; leader_i = 1'b0;
    step(1, 8'hA0 | 8'd17, 1);      // 101_10001 matches stored id 5
    step(0, 0, 0);
    chk(flag_oe_o == 1'b1, "R1 old id still matches", int'(flag_oe_o), 1);
    chk(local_q_o == 5'd17, "R1/R7 local_q", int'(local_q_o), 17);
    step(1, 8'h40, 0);              // 010_00000: new pin value, must miss
    step(0, 0, 0);
    chk(flag_oe_o == 1'b0, "R1 new pins ignored", int'(flag_oe_o), 0);

    phase = "R5 idle address changes";
    for (int i = 0; i < 8; i++) step(0, 8'hA0 + i, 1'($urandom));
    step(0, 0, 0);
    chk(flag_oe_o == 1'b0, "R5 hold off", int'(flag_oe_o), 0);

    phase = "R3 R4 sweep id5";
    for (int a = 0; a < 256; a++) step(1, a, 1'($urandom));
    for (int i = 0; i < 40; i++) step(1'($urandom), $urandom_range(0, 255), 1'($urandom));

    // follower
    phase = "R2 follower id0";
    do_reset(0, 0);
    for (int i = 0; i < 3; i++) step(0, $urandom_range(0, 255), 1'($urandom));
    step(0, 0, 0);
    chk(flag_oe_o == 1'b0, "R2 follower off", int'(flag_oe_o), 0);
    phase = "R3 follower takes";
    step(1, 8'h1F, 1);
    step(0, 8'hFF, 0);
    chk(flag_oe_o == 1'b1, "R3 take", int'(flag_oe_o), 1);
    chk(local_q_o == 5'd31, "R7 capture", int'(local_q_o), 31);
    phase = "R4 miss releases";
    step(1, 8'h20, 1);
    step(0, 0, 1);
    chk(flag_oe_o == 1'b0, "R4 release", int'(flag_oe_o), 0);
    chk(local_q_o == 5'd31, "R7 hold on miss", int'(local_q_o), 31);
    phase = "R3 R4 R6 sweep id0";
    for (int a = 255; a >= 0; a--) step(1, a, 1'($urandom));

    // every other number, random mix
    for (int id = 1; id < 8; id++) begin
      phase = $sformatf("R3 R4 R5 R6 R7 mix id%0d", id);
      do_reset(id, 1'(id % 2));
      for (int i = 0; i < 120; i++)
        step(1'($urandom_range(0, 2) == 0), (($urandom_range(0, 1) != 0) ? id * 32 : $urandom_range(0, 7) * 32) + $urandom_range(0, 31), 1'($urandom));
    end
    step(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule